// File: doc/BRIEF.md
# Crossing-Tagged Multi-Lane Link Receiver

This block accepts words from several front-end links. Each link has its own recovered clock. The block moves the words into the system trigger clock, which ticks once per 25 ns crossing. Each link writes into its own small dual-clock queue. The queues pass their Gray-coded pointers between the two domains through two-flop synchronizers. On the trigger side a crossing counter runs freely. A periodic orbit marker brings it back to zero, and it also wraps by itself at the end of the orbit length. Every word that leaves the block carries the counter value of the cycle in which it was read.

The lanes stay aligned. After reset, and after any slip, the read side waits until every queue holds at least a programmable number of words. It then reads all queues together in every cycle. Words written into the same position of each lane's stream therefore always leave in the same output beat.

Three sticky flags report pipeline trouble: an orbit marker out of place, a word lost to a full queue, and a lane that ran dry while the pipeline was running. A reset clears the flags.

Top module: `rx_bx_align`

## Requirements
- R1: Each lane delivers its accepted words in the order they were written, with no duplicate and no loss, across the link-clock to system-clock crossing.
- R2: While the pipeline is not running, outValid stays 0 until every lane's queue, as seen from the system clock, holds at least startLevel words. The pipeline then starts, and reads begin in the following cycle.
- R3: Each outValid beat carries exactly one word from every lane in outData, with lane i in bits [i*DATA_W +: DATA_W]. The k-th word read from any lane is always paired with the k-th word read from every other lane.
- R4: The crossing counter is 0 after reset and advances by one per system clock. With no marker, it goes from ORBIT-1 to 0.
- R5: bc0 high at a rising system clock edge makes the counter 0 after that edge. outBx is the counter value held just before the edge at which the word was read.
- R6: errOrbit is set when bc0 arrives at an edge where the counter is not ORBIT-1. The first bc0 after reset is exempt. errOrbit stays set until reset.
- R7: A word presented while its lane's queue is full is dropped and never emitted. errOverflow is then set in the system domain and stays set until reset.
- R8: If any lane is empty while the pipeline runs, no lane is read in that cycle. errUnderflow is set and stays set until reset, and the pipeline returns to waiting for startLevel words on every lane.
- R9: After reset, outValid, errOrbit, errOverflow and errUnderflow are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sysClk | input | 1 | System trigger clock, one period per crossing |
| sysRstN | input | 1 | Asynchronous active-low reset, system domain |
| linkClk | input | LANES | Recovered clock of each link |
| linkRstN | input | LANES | Asynchronous active-low reset of each link domain |
| linkValid | input | LANES | Word present on the lane in this link cycle |
| linkData | input | LANES*DATA_W | Lane words, lane i at [i*DATA_W +: DATA_W] |
| bc0 | input | 1 | Orbit marker, system domain |
| startLevel | input | ADDR_W+1 | Words each lane must hold before reads start |
| outValid | output | 1 | Aligned beat present |
| outData | output | LANES*DATA_W | One word per lane, same crossing |
| outBx | output | BX_W | Crossing number of the beat |
| errOrbit | output | 1 | Sticky: orbit marker out of place |
| errOverflow | output | 1 | Sticky: a lane dropped a word when full |
| errUnderflow | output | 1 | Sticky: a lane ran dry while running |

## Verification
The bench builds the block with two lanes, 8-bit words, 16-entry queues and an orbit of 20 crossings. The short orbit lets several counter wraps, correctly placed markers and a misplaced marker fit inside a stream of about a hundred words. The 16-entry depth leaves room for the pointer-synchronizer lag at start levels up to six. A full queue can still be reached in twenty writes while the partner lane stays silent. The two link clocks share the system rate but have distinct phase offsets. Because of these offsets, each lane's words cross the domain boundary at a different point in the cycle.

// File: rtl/rxa_pkg.sv
package rxa_pkg;
  // Strobe bundle from control to datapath, system clock domain
  typedef struct packed {
    logic popAll;   // advance every lane queue and load the output beat
  } rxStrobe_t;
endpackage

// File: rtl/rxa_lane_fifo.sv
module rxa_lane_fifo #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 4     // must be 2 or more
) (
  input  logic              wrClk,
  input  logic              wrRstN,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  output logic              wrOverflow,
  input  logic              rdClk,
  input  logic              rdRstN,
  input  logic              rdEn,
  output logic [DATA_W-1:0] rdData,
  output logic [ADDR_W:0]   rdLevel,
  output logic              rdEmpty
);
  localparam int PW    = ADDR_W + 1;
  localparam int DEPTH = 1 << ADDR_W;

  function automatic logic [PW-1:0] toGray(input logic [PW-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [PW-1:0] toBin(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic [DATA_W-1:0] mem [DEPTH];
  logic [PW-1:0] wBin, wGray, wNext;
  logic [PW-1:0] rBin, rGray, rNext;
  logic [PW-1:0] rGrayMeta, rGraySync, wGrayMeta, wGraySync;
  logic wFull;

  // write domain
  assign wNext = wBin + 1'b1;
  assign wFull = (wGray == {~rGraySync[PW-1:PW-2], rGraySync[PW-3:0]});

  always_ff @(posedge wrClk or negedge wrRstN) begin
    if (!wrRstN) begin
      wBin       <= '0;
      wGray      <= '0;
      wrOverflow <= 1'b0;
    end else if (wrEn) begin
      if (wFull) begin
        wrOverflow <= 1'b1;
      end else begin
        wBin  <= wNext;
        wGray <= toGray(wNext);
      end
    end
  end

  always_ff @(posedge wrClk) begin
    if (wrEn && !wFull) mem[wBin[ADDR_W-1:0]] <= wrData;
  end

  always_ff @(posedge wrClk or negedge wrRstN) begin
    if (!wrRstN) begin
      rGrayMeta <= '0;
      rGraySync <= '0;
    end else begin
      rGrayMeta <= rGray;
      rGraySync <= rGrayMeta;
    end
  end

  // read domain
  assign rNext   = rBin + 1'b1;
  assign rdEmpty = (wGraySync == rGray);
  assign rdLevel = toBin(wGraySync) - rBin;
  assign rdData  = mem[rBin[ADDR_W-1:0]];

  always_ff @(posedge rdClk or negedge rdRstN) begin
    if (!rdRstN) begin
      rBin  <= '0;
      rGray <= '0;
    end else if (rdEn && !rdEmpty) begin
      rBin  <= rNext;
      rGray <= toGray(rNext);
    end
  end

  always_ff @(posedge rdClk or negedge rdRstN) begin
    if (!rdRstN) begin
      wGrayMeta <= '0;
      wGraySync <= '0;
    end else begin
      wGrayMeta <= wGray;
      wGraySync <= wGrayMeta;
    end
  end
endmodule

// File: rtl/rxa_datapath.sv
module rxa_datapath
  import rxa_pkg::*;
#(
  parameter int LANES  = 4,
  parameter int DATA_W = 16,
  parameter int ADDR_W = 4,
  parameter int BX_W   = 12
) (
  input  logic [LANES-1:0]            linkClk,
  input  logic [LANES-1:0]            linkRstN,
  input  logic [LANES-1:0]            linkValid,
  input  logic [LANES*DATA_W-1:0]     linkData,
  input  logic                        sysClk,
  input  logic                        sysRstN,
  input  rxStrobe_t                   strobe,
  input  logic [BX_W-1:0]             bxNow,
  output logic [LANES*(ADDR_W+1)-1:0] laneLevel,
  output logic [LANES-1:0]            laneEmpty,
  output logic                        outValid,
  output logic [LANES*DATA_W-1:0]     outData,
  output logic [BX_W-1:0]             outBx,
  output logic                        errOverflow
);
  localparam int LW = ADDR_W + 1;

  logic [LANES*DATA_W-1:0] laneData;
  logic [LANES-1:0] laneOvf, ovfMeta, ovfSync;

  for (genvar g = 0; g < LANES; g++) begin : gLane
    rxa_lane_fifo #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) uFifo (
      .wrClk     (linkClk[g]),
      .wrRstN    (linkRstN[g]),
      .wrEn      (linkValid[g]),
      .wrData    (linkData[g*DATA_W +: DATA_W]),
      .wrOverflow(laneOvf[g]),
      .rdClk     (sysClk),
      .rdRstN    (sysRstN),
      .rdEn      (strobe.popAll),
      .rdData    (laneData[g*DATA_W +: DATA_W]),
      .rdLevel   (laneLevel[g*LW +: LW]),
      .rdEmpty   (laneEmpty[g])
    );
  end

  // sticky per-lane overflow brought into the system domain
  always_ff @(posedge sysClk or negedge sysRstN) begin
    if (!sysRstN) begin
      ovfMeta <= '0;
      ovfSync <= '0;
    end else begin
      ovfMeta <= laneOvf;
      ovfSync <= ovfMeta;
    end
  end
  assign errOverflow = |ovfSync;

  always_ff @(posedge sysClk or negedge sysRstN) begin
    if (!sysRstN) begin
      outValid <= 1'b0;
      outData  <= '0;
      outBx    <= '0;
    end else begin
      outValid <= strobe.popAll;
      if (strobe.popAll) begin
        outData <= laneData;
        outBx   <= bxNow;
      end
    end
  end
endmodule

// File: rtl/rxa_control.sv
module rxa_control
  import rxa_pkg::*;
#(
  parameter int LANES  = 4,
  parameter int ADDR_W = 4,
  parameter int ORBIT  = 3564,
  parameter int BX_W   = 12
) (
  input  logic                        sysClk,
  input  logic                        sysRstN,
  input  logic                        bc0,
  input  logic [ADDR_W:0]             startLevel,
  input  logic [LANES*(ADDR_W+1)-1:0] laneLevel,
  input  logic [LANES-1:0]            laneEmpty,
  output rxStrobe_t                   strobe,
  output logic [BX_W-1:0]             bxNow,
  output logic                        errOrbit,
  output logic                        errUnderflow
);
  localparam int LW = ADDR_W + 1;
  localparam logic [BX_W-1:0] BX_LAST = BX_W'(ORBIT - 1);

  logic running, locked, allReady, anyEmpty;

  always_comb begin
    allReady = 1'b1;
    anyEmpty = 1'b0;
    for (int i = 0; i < LANES; i++) begin
      if (laneEmpty[i] || (laneLevel[i*LW +: LW] < startLevel)) allReady = 1'b0;
      anyEmpty = anyEmpty | laneEmpty[i];
    end
  end

  assign strobe.popAll = running && !anyEmpty;

  // crossing counter and orbit check
  always_ff @(posedge sysClk or negedge sysRstN) begin
    if (!sysRstN) begin
      bxNow    <= '0;
      locked   <= 1'b0;
      errOrbit <= 1'b0;
    end else begin
      if (bc0 || bxNow == BX_LAST) bxNow <= '0;
      else                         bxNow <= bxNow + 1'b1;
      if (bc0) locked <= 1'b1;
      if (bc0 && locked && bxNow != BX_LAST) errOrbit <= 1'b1;
    end
  end

  // priming and lockstep run state
  always_ff @(posedge sysClk or negedge sysRstN) begin
    if (!sysRstN) begin
      running      <= 1'b0;
      errUnderflow <= 1'b0;
    end else if (!running) begin
      running <= allReady;
    end else if (anyEmpty) begin
      running      <= 1'b0;
      errUnderflow <= 1'b1;
    end
  end
endmodule

// File: rtl/rx_bx_align.sv
module rx_bx_align
  import rxa_pkg::*;
#(
  parameter int LANES  = 4,
  parameter int DATA_W = 16,
  parameter int ADDR_W = 4,
  parameter int ORBIT  = 3564,
  parameter int BX_W   = $clog2(ORBIT)
) (
  input  logic                    sysClk,
  input  logic                    sysRstN,
  input  logic [LANES-1:0]        linkClk,
  input  logic [LANES-1:0]        linkRstN,
  input  logic [LANES-1:0]        linkValid,
  input  logic [LANES*DATA_W-1:0] linkData,
  input  logic                    bc0,
  input  logic [ADDR_W:0]         startLevel,
  output logic                    outValid,
  output logic [LANES*DATA_W-1:0] outData,
  output logic [BX_W-1:0]         outBx,
  output logic                    errOrbit,
  output logic                    errOverflow,
  output logic                    errUnderflow
);
  rxStrobe_t                   strobe;
  logic [BX_W-1:0]             bxNow;
  logic [LANES*(ADDR_W+1)-1:0] laneLevel;
  logic [LANES-1:0]            laneEmpty;

  rxa_control #(.LANES(LANES), .ADDR_W(ADDR_W), .ORBIT(ORBIT), .BX_W(BX_W)) uCtrl (
    .sysClk      (sysClk),
    .sysRstN     (sysRstN),
    .bc0         (bc0),
    .startLevel  (startLevel),
    .laneLevel   (laneLevel),
    .laneEmpty   (laneEmpty),
    .strobe      (strobe),
    .bxNow       (bxNow),
    .errOrbit    (errOrbit),
    .errUnderflow(errUnderflow)
  );

  rxa_datapath #(.LANES(LANES), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .BX_W(BX_W)) uData (
    .linkClk    (linkClk),
    .linkRstN   (linkRstN),
    .linkValid  (linkValid),
    .linkData   (linkData),
    .sysClk     (sysClk),
    .sysRstN    (sysRstN),
    .strobe     (strobe),
    .bxNow      (bxNow),
    .laneLevel  (laneLevel),
    .laneEmpty  (laneEmpty),
    .outValid   (outValid),
    .outData    (outData),
    .outBx      (outBx),
    .errOverflow(errOverflow)
  );
endmodule

// File: rtl/rxa_checker.sv
module rxa_checker #(
  parameter int ORBIT = 3564,
  parameter int BX_W  = 12
) (
  input logic            sysClk,
  input logic            sysRstN,
  input logic            bc0,
  input logic            outValid,
  input logic [BX_W-1:0] outBx,
  input logic            errOrbit,
  input logic            errOverflow,
  input logic            errUnderflow
);
  localparam logic [BX_W-1:0] BX_LAST = BX_W'(ORBIT - 1);

  AST_ORBIT_STICKY: assert property (@(posedge sysClk) disable iff (!sysRstN)
    errOrbit |=> errOrbit); // R6
  AST_OVERFLOW_STICKY: assert property (@(posedge sysClk) disable iff (!sysRstN)
    errOverflow |=> errOverflow); // R7
  AST_UNDERFLOW_STICKY: assert property (@(posedge sysClk) disable iff (!sysRstN)
    errUnderflow |=> errUnderflow); // R8
  AST_TAG_IN_ORBIT: assert property (@(posedge sysClk) disable iff (!sysRstN)
    outValid |-> (outBx <= BX_LAST)); // R4
  AST_TAG_STEP: assert property (@(posedge sysClk) disable iff (!sysRstN)
    (outValid && $past(outValid) && !$past(bc0, 2)) |->
      (outBx == (($past(outBx) == BX_LAST) ? '0 : $past(outBx) + 1'b1))); // R4
  AST_TAG_MARKER: assert property (@(posedge sysClk) disable iff (!sysRstN)
    (outValid && $past(outValid) && $past(bc0, 2)) |-> (outBx == '0)); // R5
endmodule

bind rx_bx_align rxa_checker #(.ORBIT(ORBIT), .BX_W(BX_W)) uChk (
  .sysClk      (sysClk),
  .sysRstN     (sysRstN),
  .bc0         (bc0),
  .outValid    (outValid),
  .outBx       (outBx),
  .errOrbit    (errOrbit),
  .errOverflow (errOverflow),
  .errUnderflow(errUnderflow)
);

// File: tb/sim_rx_bx_align.sv
`timescale 1ns/100ps
module sim_rx_bx_align;
  localparam int LANES = 2, DW = 8, AW = 4, ORB = 20;
  localparam int BXW = $clog2(ORB), DEPTH = 1 << AW;

  logic sysClk = 0, lk0 = 0, lk1 = 0;
  logic sysRstN = 0;
  logic [1:0] linkRstN = 2'b00;
  logic v0 = 0, v1 = 0;
  logic [DW-1:0] d0 = 0, d1 = 0;
  logic bc0 = 0;
  logic [AW:0] startLevel = 4;
  logic outValid, errOrbit, errOverflow, errUnderflow;
  logic [LANES*DW-1:0] outData;
  logic [BXW-1:0] outBx;

  initial forever #2 sysClk = ~sysClk;
  initial begin #0.7; forever #2 lk0 = ~lk0; end
  initial begin #1.9; forever #2 lk1 = ~lk1; end

  rx_bx_align #(.LANES(LANES), .DATA_W(DW), .ADDR_W(AW), .ORBIT(ORB)) u0 (
    .sysClk(sysClk), .sysRstN(sysRstN), .linkClk({lk1, lk0}), .linkRstN(linkRstN),
    .linkValid({v1, v0}), .linkData({d1, d0}), .bc0(bc0), .startLevel(startLevel),
    .outValid(outValid), .outData(outData), .outBx(outBx), .errOrbit(errOrbit),
    .errOverflow(errOverflow), .errUnderflow(errUnderflow));

  int nRun = 0, nFail = 0;
  logic [DW-1:0] q0[$], q1[$];
  logic [DW-1:0] arr[100];
  bit expectIdle = 0, firstReq = 0, goodMode = 0, badReq = 0;
  int mBx = 0, prevBx = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nRun++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic int nextBx(input int bx, input bit mark);
    if (mark || bx == ORB - 1) return 0;
    return bx + 1;
  endfunction

  // reference crossing counter (R4, R5)
  always @(posedge sysClk) begin
    if (!sysRstN) begin mBx = 0; prevBx = 0; end
    else begin prevBx = mBx; mBx = nextBx(mBx, bc0); end
  end

  // orbit marker driver
  always @(negedge sysClk) begin
    bc0 = 0;
    if (firstReq && mBx == 7) begin bc0 = 1; firstReq = 0; end
    else if (goodMode && !firstReq && mBx == ORB - 1) bc0 = 1;
    if (badReq && mBx == 5) begin bc0 = 1; badReq = 0; end
  end

  // output monitor
  always @(negedge sysClk) begin
    if (sysRstN && outValid) begin
      logic [DW-1:0] e0, e1;
      if (expectIdle) chk(0, "R2 beat before start level", 1, 0);
      chk(q0.size() > 0 && q1.size() > 0, "R1 unexpected beat", 1, 0);
      if (q0.size() > 0 && q1.size() > 0) begin
        e0 = q0.pop_front();
        e1 = q1.pop_front();
        chk(outData[DW-1:0] == e0, "R1 lane0 word", int'(outData[DW-1:0]), int'(e0));
        chk(outData[2*DW-1:DW] == e1, "R1 lane1 word", int'(outData[2*DW-1:DW]), int'(e1));
      end
      chk(outData[2*DW-1:DW] == (outData[DW-1:0] ^ 8'h5A), "R3 lockstep pair",
          int'(outData[2*DW-1:DW]), int'(outData[DW-1:0] ^ 8'h5A));
      chk(int'(outBx) == prevBx, "R4/R5 crossing tag", int'(outBx), prevBx);
    end
  end

  task automatic send0(input logic [DW-1:0] x, input bit keep);
    @(negedge lk0); v0 = 1; d0 = x; if (keep) q0.push_back(x);
  endtask
  task automatic send1(input logic [DW-1:0] x, input bit keep);
    @(negedge lk1); v1 = 1; d1 = x; if (keep) q1.push_back(x);
  endtask
  task automatic stop0; @(negedge lk0); v0 = 0; endtask
  task automatic stop1; @(negedge lk1); v1 = 0; endtask

  task automatic sendBoth(input int n, input int base);
    fork
      begin for (int i = 0; i < n; i++) send0(arr[base+i], 1); stop0(); end
      begin for (int i = 0; i < n; i++) send1(arr[base+i] ^ 8'h5A, 1); stop1(); end
    join
  endtask

  task automatic waitSys(input int n);
    repeat (n) @(negedge sysClk);
  endtask

  task automatic doReset;
    @(negedge sysClk);
    sysRstN = 0; linkRstN = 2'b00; v0 = 0; v1 = 0;
    firstReq = 0; goodMode = 0; badReq = 0; expectIdle = 0;
    q0.delete(); q1.delete();
    waitSys(4);
    sysRstN = 1; linkRstN = 2'b11;
    waitSys(2);
  endtask

  initial begin
    repeat (50000) @(posedge sysClk);
    nFail++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    void'($urandom(32'd2718));
    for (int i = 0; i < 100; i++) arr[i] = DW'($urandom);

    // R9 reset state
    doReset();
    chk(outValid == 0, "R9 outValid", int'(outValid), 0);
    chk(errOrbit == 0, "R9 errOrbit", int'(errOrbit), 0);
    chk(errOverflow == 0, "R9 errOverflow", int'(errOverflow), 0);
    chk(errUnderflow == 0, "R9 errUnderflow", int'(errUnderflow), 0);

    // R2 start threshold: three words per lane must not start the pipeline
    startLevel = 4; expectIdle = 1;
    sendBoth(3, 0);
    waitSys(20);
    chk(outValid == 0, "R2 held below level", int'(outValid), 0);
    expectIdle = 0;
    sendBoth(1, 3);
    waitSys(30);
    chk(q0.size() == 0, "R1 lane0 drained", q0.size(), 0);
    chk(q1.size() == 0, "R3 lane1 drained", q1.size(), 0);
    chk(errUnderflow == 1, "R8 dry after drain", int'(errUnderflow), 1);
    chk(outValid == 0, "R8 stopped", int'(outValid), 0);

    // random stream with orbit markers (R1 R3 R4 R5 R6)
    doReset();
    startLevel = AW'($urandom_range(2, 6));
    firstReq = 1; goodMode = 1;
    sendBoth(100, 0);
    waitSys(40);
    chk(q0.size() == 0 && q1.size() == 0, "R1 stream drained", q0.size() + q1.size(), 0);
    chk(errOrbit == 0, "R6 first and aligned markers", int'(errOrbit), 0);
    chk(errOverflow == 0, "R7 no overflow in stream", int'(errOverflow), 0);
    badReq = 1;
    waitSys(ORB + 5);
    chk(errOrbit == 1, "R6 misplaced marker", int'(errOrbit), 1);
    waitSys(2 * ORB);
    chk(errOrbit == 1, "R6 sticky", int'(errOrbit), 1);

    // R7 overflow: lane0 fills while lane1 is silent
    doReset();
    startLevel = 4; expectIdle = 1;
    for (int i = 0; i < 20; i++) send0(arr[i], i < DEPTH);
    stop0();
    waitSys(10);
    chk(errOverflow == 1, "R7 overflow flag", int'(errOverflow), 1);
    chk(outValid == 0, "R2 one lane empty", int'(outValid), 0);
    expectIdle = 0;
    for (int i = 0; i < DEPTH; i++) send1(arr[i] ^ 8'h5A, 1);
    stop1();
    waitSys(40);
    chk(q0.size() == 0, "R7 dropped words absent", q0.size(), 0);
    chk(q1.size() == 0, "R1 lane1 drained", q1.size(), 0);
    chk(errOverflow == 1, "R7 sticky", int'(errOverflow), 1);

    // R8 slip mid-stream and resume in step
    doReset();
    startLevel = 3;
    sendBoth(4, 0);
    for (int i = 4; i < 8; i++) send0(arr[i], 1);
    stop0();
    waitSys(30);
    chk(q0.size() == 4, "R8 no read while a lane is dry", q0.size(), 4);
    chk(q1.size() == 0, "R8 lane1 consumed", q1.size(), 0);
    chk(errUnderflow == 1, "R8 underflow flag", int'(errUnderflow), 1);
    chk(outValid == 0, "R8 waiting", int'(outValid), 0);
    for (int i = 4; i < 8; i++) send1(arr[i] ^ 8'h5A, 1);
    stop1();
    waitSys(30);
    chk(q0.size() == 0 && q1.size() == 0, "R3 resumed in step", q0.size() + q1.size(), 0);

    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule